// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous memory with a shared data bus. Each word is 36 bits wide, split into four 9-bit byte lanes, and the number of words is set by an address-width parameter. Address and control are registered on the rising clock edge. Read data then appears combinationally in the same cycle, so the memory works in flow-through mode.

Write data follows its address by one cycle and is parked in a one-entry write registry. The registry is drained into the array on a later write or idle cycle. A read that hits the parked address gets the parked lanes merged over the array contents. Because of this, any sequence of reads and writes moves one word per clock with no dead cycles on the bus.

A clock enable freezes the whole block. A sleep input turns accesses away. Three chip selects must all be active for a cycle to count. An unregistered output enable gates the bus drivers directly. A separate address sequencer drives `addr` on continue cycles.

Top module: `nolat_sram`

## Requirements
- R1: Address and control are sampled on the rising edge. A selected read (`adv_ld`=0, all `chip_sel` bits 1, `we`=0) presents the word at that address on `dq_out` with `dq_oe`=1 in the cycle right after that edge, provided `oe`=1 and `sleep`=0.
- R2: On a write, `byte_wr` is sampled with the address. Lane i occupies bits [9i+8:9i]. Only lanes whose `byte_wr[i]`=1 change, and the other lanes keep their previous contents.
- R3: Write data is taken from `dq_in` on the edge after the write address edge. In the cycle between those two edges, `dq_oe` is 0.
- R4: A read of the address whose write data is still parked returns the parked lanes merged over the stored word, lane by lane. A read issued right after a write to the same address therefore returns the new data.
- R5: Reads and writes may follow each other in any order on consecutive cycles. Every read returns correct data with no wait or idle cycle in between.
- R6: A cycle is selected only when all three `chip_sel` bits are 1. A load cycle without full selection writes nothing and leaves `dq_oe` at 0.
- R7: While `clk_en`=0, an edge has no effect. `dq_out` and `dq_oe` keep their values, and a read or write presented on that edge is not performed.
- R8: `oe` acts on `dq_oe` with no clock edge. Dropping `oe` during a read cycle clears `dq_oe` at once, and raising it restores `dq_oe`.
- R9: With `sleep`=1, presented reads and writes are not performed, and `dq_oe` is 0.
- R10: On a continue cycle (`adv_ld`=1), `chip_sel` and `we` are ignored. The cycle repeats the operation of the most recent load cycle (read, write or deselect) at the address now on `addr`.
- R11: After reset, `dq_oe` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock qualifier; 0 freezes all state |
| addr | input | ADDR_W | Word address |
| adv_ld | input | 1 | 0 = load a new operation, 1 = continue the last operation |
| we | input | 1 | 1 = write, 0 = read (load cycles) |
| byte_wr | input | LANES | Per-lane write select |
| chip_sel | input | NUM_SEL | Chip selects, all must be 1 |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Low-power request; accesses are refused |
| dq_in | input | LANES*LANE_W | Data bus, inbound half |
| dq_out | output | LANES*LANE_W | Data bus, outbound half |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The hardest case to reach is a read that lands on a word whose write is still parked and only partly masked. Reaching it needs a partial-lane write followed at once by a read of the same address. The read's address edge must coincide with the edge that captures the write data, so the reply has to be assembled from the registry and the array together. The vector table builds exactly that pattern, surrounds it with interleaved full writes and reads, and includes a forced drain of the registry by a back-to-back write. Directed sequences then cover stalls, sleep and the asynchronous enable in the middle of a read.

// File: rtl/nolat_sram_pkg.sv
package nolat_sram_pkg;

  // Operation kind carried from the input stage to the rest of the block
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

endpackage

// File: rtl/nolat_sram_ctl.sv
// Input stage: decodes the operation and registers address and lane mask
module nolat_sram_ctl
  import nolat_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int NUM_SEL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en,
  input  logic               sleep,
  input  logic               adv_ld,
  input  logic [NUM_SEL-1:0] chip_sel,
  input  logic               we,
  input  logic [LANES-1:0]   byte_wr,
  input  logic [ADDR_W-1:0]  addr,
  output op_e                op_next,
  output op_e                op_q,
  output logic [ADDR_W-1:0]  addr_q,
  output logic [LANES-1:0]   mask_q
);

  op_e last_q;
  op_e last_d;

  always_comb begin
    last_d = last_q;
    if (sleep) begin
      op_next = OP_IDLE;
    end else if (adv_ld) begin
      op_next = last_q;
    end else begin
      if (&chip_sel) op_next = we ? OP_WR : OP_RD;
      else           op_next = OP_IDLE;
      last_d = op_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      last_q <= OP_IDLE;
      addr_q <= '0;
      mask_q <= '0;
    end else if (clk_en) begin
      op_q   <= op_next;
      last_q <= last_d;
      addr_q <= addr;
      mask_q <= byte_wr;
    end
  end

endmodule

// File: rtl/nolat_sram_wreg.sv
// One-entry write registry: holds late write data until the array port is free
module nolat_sram_wreg
  import nolat_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sleep,
  input  op_e               op_q,
  input  op_e               op_next,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [LANES-1:0]  mask_q,
  input  logic [WORD_W-1:0] din,
  output logic              pend_q,
  output logic [ADDR_W-1:0] pa_q,
  output logic [LANES-1:0]  pm_q,
  output logic [WORD_W-1:0] pd_q,
  output logic              commit
);

  logic              load;
  logic              pend_d;
  logic [ADDR_W-1:0] pa_d;
  logic [LANES-1:0]  pm_d;
  logic [WORD_W-1:0] pd_d;

  always_comb begin
    // data phase of the previously registered write
    load   = clk_en && (op_q == OP_WR);
    // drain when overwritten, or when the array port is not needed by a read
    commit = clk_en && pend_q && (load || (!sleep && (op_next != OP_RD)));
    pend_d = pend_q;
    pa_d   = pa_q;
    pm_d   = pm_q;
    pd_d   = pd_q;
    if (load) begin
      pend_d = 1'b1;
      pa_d   = addr_q;
      pm_d   = mask_q;
      pd_d   = din;
    end else if (commit) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pa_q   <= '0;
      pm_q   <= '0;
      pd_q   <= '0;
    end else begin
      pend_q <= pend_d;
      pa_q   <= pa_d;
      pm_q   <= pm_d;
      pd_q   <= pd_d;
    end
  end

endmodule

// File: rtl/nolat_sram_array.sv
// Storage: one memory per byte lane, synchronous write, combinational read
module nolat_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANES-1:0]  wmask,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wmask[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/nolat_sram_rdpath.sv
// Read path: registry forwarding per lane and bus driver control
module nolat_sram_rdpath
  import nolat_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  op_e               op_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              pend_q,
  input  logic [ADDR_W-1:0] pa_q,
  input  logic [LANES-1:0]  pm_q,
  input  logic [WORD_W-1:0] pd_q,
  input  logic [WORD_W-1:0] arr_rd,
  input  logic              oe,
  input  logic              sleep,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);

  logic              hit;
  logic              is_rd;
  logic [WORD_W-1:0] merged;

  assign hit   = pend_q && (pa_q == addr_q);
  assign is_rd = (op_q == OP_RD);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign merged[l*LANE_W +: LANE_W] = (hit && pm_q[l]) ? pd_q[l*LANE_W +: LANE_W]
                                                          : arr_rd[l*LANE_W +: LANE_W];
  end

  assign dq_out = is_rd ? merged : '0;
  // write data phase and idle cycles leave the bus released
  assign dq_oe  = is_rd && oe && !sleep;

endmodule

// File: rtl/nolat_sram.sv
// Top: flow-through synchronous SRAM with late-write registry
module nolat_sram
  import nolat_sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int NUM_SEL = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      adv_ld,
  input  logic                      we,
  input  logic [LANES-1:0]          byte_wr,
  input  logic [NUM_SEL-1:0]        chip_sel,
  input  logic                      oe,
  input  logic                      sleep,
  input  logic [LANES*LANE_W-1:0]   dq_in,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_oe
);

  localparam int WORD_W = LANES * LANE_W;

  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  op_e               op_next;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic              pend_q;
  logic [ADDR_W-1:0] pa_q;
  logic [LANES-1:0]  pm_q;
  logic [WORD_W-1:0] pd_q;
  logic              commit;
  logic [WORD_W-1:0] arr_rd;

  nolat_sram_ctl #(
    .ADDR_W(ADDR_W), .LANES(LANES), .NUM_SEL(NUM_SEL)
  ) u_ctl (
    .clk(clk), .rst_n(rst_core_n), .clk_en(clk_en), .sleep(sleep),
    .adv_ld(adv_ld), .chip_sel(chip_sel), .we(we), .byte_wr(byte_wr),
    .addr(addr), .op_next(op_next), .op_q(op_q), .addr_q(addr_q),
    .mask_q(mask_q)
  );

  nolat_sram_wreg #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_wreg (
    .clk(clk), .rst_n(rst_core_n), .clk_en(clk_en), .sleep(sleep),
    .op_q(op_q), .op_next(op_next), .addr_q(addr_q), .mask_q(mask_q),
    .din(dq_in), .pend_q(pend_q), .pa_q(pa_q), .pm_q(pm_q), .pd_q(pd_q),
    .commit(commit)
  );

  nolat_sram_array #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_array (
    .clk(clk), .wr_en(commit), .waddr(pa_q), .wmask(pm_q), .wdata(pd_q),
    .raddr(addr_q), .rdata(arr_rd)
  );

  nolat_sram_rdpath #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_rdpath (
    .op_q(op_q), .addr_q(addr_q), .pend_q(pend_q), .pa_q(pa_q),
    .pm_q(pm_q), .pd_q(pd_q), .arr_rd(arr_rd), .oe(oe), .sleep(sleep),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

endmodule

// File: rtl/nolat_sram_chk.sv
// Port-level temporal checks, attached to the top by bind
module nolat_sram_chk #(
  parameter int WORD_W  = 36,
  parameter int NUM_SEL = 3
) (
  input logic               clk,
  input logic               rst_ok,
  input logic               clk_en,
  input logic               sleep,
  input logic               adv_ld,
  input logic [NUM_SEL-1:0] chip_sel,
  input logic               we,
  input logic               oe,
  input logic               dq_oe,
  input logic [WORD_W-1:0]  dq_out
);

  assert_rd_drives_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    (clk_en && !sleep && !adv_ld && (&chip_sel) && !we) |=> (dq_oe || !oe || sleep));

  assert_wr_phase_released_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (clk_en && !sleep && !adv_ld && (&chip_sel) && we) |=> !dq_oe);

  assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (clk_en && !sleep && !adv_ld && !(&chip_sel)) |=> !dq_oe);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    !clk_en |=> $stable(dq_out));

  assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    (clk_en && sleep) |=> !dq_oe);

endmodule

bind nolat_sram nolat_sram_chk #(.WORD_W(WORD_W), .NUM_SEL(NUM_SEL)) u_chk (
  .clk(clk), .rst_ok(rst_core_n), .clk_en(clk_en), .sleep(sleep),
  .adv_ld(adv_ld), .chip_sel(chip_sel), .we(we), .oe(oe),
  .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/nolat_sram_bench.sv
module nolat_sram_bench;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 90;

  // vector: {load, sel[2:0], we, bw[3:0], addr[7:0], din[35:0], exp_oe, exp_data[35:0]}
  function automatic logic [VW-1:0] mkv(input logic ld, input logic [2:0] sel,
      input logic w, input logic [3:0] bw, input logic [7:0] a,
      input logic [35:0] d, input logic eoe, input logic [35:0] ed);
    return {ld, sel, w, bw, a, d, eoe, ed};
  endfunction

  localparam logic [35:0] D_A0 = 36'h111111111;
  localparam logic [35:0] D_A1 = 36'h222222222;
  localparam logic [35:0] D_B  = 36'h9ABCDEF01;
  localparam logic [35:0] D_C  = 36'h333333333;
  localparam logic [35:0] D_J  = 36'hDEADBEEF0;
  localparam logic [35:0] D_E  = 36'h444444444;
  localparam logic [35:0] D_F  = 36'h555555555;
  localparam logic [35:0] MRG  = {D_A0[35:18], D_B[17:0]};

  localparam int NV = 15;
  localparam logic [VW-1:0] VEC [NV] = '{
    mkv(1, 3'b111, 1, 4'hF, 8'h10, 36'h0, 0, 36'h0),   // R3 write address
    mkv(1, 3'b111, 1, 4'hF, 8'h11, D_A0,  0, 36'h0),   // R5 write after write
    mkv(1, 3'b111, 0, 4'h0, 8'h10, D_A1,  1, D_A0),    // R1 read from array
    mkv(1, 3'b111, 0, 4'h0, 8'h11, 36'h0, 1, D_A1),    // R4 forward full word
    mkv(1, 3'b111, 1, 4'h3, 8'h10, 36'h0, 0, 36'h0),   // R2 partial write
    mkv(1, 3'b111, 0, 4'h0, 8'h10, D_B,   1, MRG),     // R4 merged lanes
    mkv(1, 3'b111, 1, 4'hF, 8'h12, 36'h0, 0, 36'h0),
    mkv(1, 3'b111, 0, 4'h0, 8'h12, D_C,   1, D_C),     // R5 write then read
    mkv(1, 3'b101, 1, 4'hF, 8'h11, 36'h0, 0, 36'h0),   // R6 deselected write
    mkv(1, 3'b111, 0, 4'h0, 8'h11, D_J,   1, D_A1),    // R6 word untouched
    mkv(0, 3'b000, 0, 4'h0, 8'h12, 36'h0, 1, D_C),     // R10 continue read
    mkv(1, 3'b111, 1, 4'hF, 8'h13, 36'h0, 0, 36'h0),
    mkv(0, 3'b000, 0, 4'hF, 8'h14, D_E,   0, 36'h0),   // R10 continue write
    mkv(1, 3'b111, 0, 4'h0, 8'h13, D_F,   1, D_E),     // R5 drained by load
    mkv(1, 3'b111, 0, 4'h0, 8'h14, 36'h0, 1, D_F)      // R10 continued write data
  };

  logic        clk;
  logic        rst_n;
  logic        clk_en;
  logic [7:0]  addr;
  logic        adv_ld;
  logic        we;
  logic [3:0]  byte_wr;
  logic [2:0]  chip_sel;
  logic        oe;
  logic        sleep;
  logic [35:0] dq_in;
  logic [35:0] dq_out;
  logic        dq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  nolat_sram u_nolat_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .addr(addr), .adv_ld(adv_ld),
    .we(we), .byte_wr(byte_wr), .chip_sel(chip_sel), .oe(oe), .sleep(sleep),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(input logic ce, input logic sl, input logic ld,
      input logic [2:0] sel, input logic w, input logic [3:0] bw,
      input logic [7:0] a, input logic [35:0] d);
    @(negedge clk);
    clk_en = ce; sleep = sl; adv_ld = !ld; chip_sel = sel;
    we = w; byte_wr = bw; addr = a; dq_in = d;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 36'h1, 36'h0);
    finish_run();
  end

  initial begin
    rst_n = 0; clk_en = 1; addr = '0; adv_ld = 0; we = 0; byte_wr = '0;
    chip_sel = '0; oe = 1; sleep = 0; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 3; k++) drv(1, 0, 1, 3'b000, 0, 4'h0, 8'h00, 36'h0);
    chk("R11 reset dq_oe", {35'b0, dq_oe}, 36'h0);

    // vector table: mixed reads and writes on consecutive cycles
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drv(1, 0, v[89], v[88:86], v[85], v[84:81], v[80:73], v[72:37]);
      chk($sformatf("R1/R3 vec%0d dq_oe", i), {35'b0, dq_oe}, {35'b0, v[36]});
      if (v[36]) chk($sformatf("R4/R5 vec%0d data", i), dq_out, v[35:0]);
    end

    // R7: stall holds outputs and ignores presented operations
    drv(1, 0, 1, 3'b111, 1, 4'hF, 8'h20, 36'h0);
    drv(1, 0, 1, 3'b111, 0, 4'h0, 8'h20, 36'h777777777);
    chk("R4 forward before stall", dq_out, 36'h777777777);
    drv(0, 0, 1, 3'b111, 0, 4'h0, 8'h10, 36'h0ABC0ABC0);
    chk("R7 stall data held", dq_out, 36'h777777777);
    chk("R7 stall oe held", {35'b0, dq_oe}, 36'h1);
    drv(0, 0, 1, 3'b111, 1, 4'hF, 8'h20, 36'h0);
    drv(0, 0, 1, 3'b000, 0, 4'h0, 8'h20, 36'h0BAD0BAD0);
    drv(1, 0, 1, 3'b111, 0, 4'h0, 8'h20, 36'h0);
    chk("R7 stalled write ignored", dq_out, 36'h777777777);

    // R9: sleep refuses accesses
    drv(1, 0, 1, 3'b111, 1, 4'hF, 8'h21, 36'h0);
    drv(1, 0, 1, 3'b000, 0, 4'h0, 8'h00, 36'h0F0F0F0F0);
    drv(1, 1, 1, 3'b111, 1, 4'hF, 8'h21, 36'h0);
    drv(1, 1, 1, 3'b000, 0, 4'h0, 8'h00, 36'h123456789);
    drv(1, 1, 1, 3'b111, 0, 4'h0, 8'h21, 36'h0);
    chk("R9 sleep read not driven", {35'b0, dq_oe}, 36'h0);
    drv(1, 0, 1, 3'b111, 0, 4'h0, 8'h21, 36'h0);
    chk("R9 sleep write ignored", dq_out, 36'h0F0F0F0F0);

    // R8: asynchronous output enable inside the read cycle
    chk("R8 oe high drives", {35'b0, dq_oe}, 36'h1);
    #1 oe = 0;
    #1 chk("R8 oe low releases", {35'b0, dq_oe}, 36'h0);
    oe = 1;
    #1 chk("R8 oe restored", {35'b0, dq_oe}, 36'h1);

    // R2: single-lane update leaves other lanes intact
    drv(1, 0, 1, 3'b111, 1, 4'hF, 8'h30, 36'h0);
    drv(1, 0, 1, 3'b000, 0, 4'h0, 8'h00, 36'hFFFFFFFFF);
    drv(1, 0, 1, 3'b111, 1, 4'b0100, 8'h30, 36'h0);
    drv(1, 0, 1, 3'b000, 0, 4'h0, 8'h00, 36'h0);
    drv(1, 0, 1, 3'b111, 0, 4'h0, 8'h30, 36'h0);
    chk("R2 lane2 only", dq_out, 36'hFFFFFFFFF ^ (36'h1FF << 18));

    finish_run();
  end

endmodule